// File: doc/BRIEF.md
# Keypad Code Debouncer

This block cleans up the 5-bit code coming from a key matrix decoder. It runs on a slow sampling clock, around 10 Hz, so that the sampling window is longer than the 5 to 10 ms of contact bounce. On every edge it writes the raw code into one slot of an eight-entry ring. A code reaches the output only after all eight slots hold the same value, which means eight consecutive samples agreed.

Downstream logic reads three results. The first is the accepted code. The second is an active-low start flag that drops on the first acceptance after reset. The third is a one-cycle key-valid pulse that fires when the accepted code changes to an actual key, so each press produces exactly one event. The all-ones code means "no key". It can be accepted like any other code, but it never raises the pulse.

Top module: `keypad_debounce`

## Requirements
- R1: While reset is low, and in the first cycle after it, the accepted code is 5'b11111, start_no is 1 and key_valid_o is 0.
- R2: When raw_code_i holds one value across 8 consecutive rising edges, the accepted code takes that value on the 9th edge and not earlier.
- R3: When the eight most recent samples are not all equal, the accepted code does not change. For example, a one-cycle glitch inside a run restarts the count of eight.
- R4: start_no falls to 0 on the first acceptance after reset and stays 0 until the next reset.
- R5: key_valid_o is high for exactly one cycle, on the edge where the accepted code changes to a value other than 5'b11111.
- R6: Accepting 5'b11111 updates the accepted code but never raises key_valid_o.
- R7: Accepting again a code equal to the current accepted code raises no key-valid pulse.
- R8: Reset preloads the eight slots with the distinct values 0 to 7, so nothing is accepted during the first 8 edges after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Debounce sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| raw_code_i | input | 5 | Raw key code from the matrix decoder, 5'b11111 = no key |
| stable_code_o | output | 5 | Last accepted (debounced) code |
| start_no | output | 1 | Low once a first code has been accepted |
| key_valid_o | output | 1 | One-cycle pulse when a new key code is accepted |

## Verification
A code held from just before edge 1 fills the ring at edge 8 and is accepted at edge 9. The accepted code, the start flag and the key-valid pulse are all due after edge 9, and the pulse is gone again after edge 10. The bench drives inputs on the falling edge and then counts rising edges exactly. It checks after 8 edges that nothing has changed yet, after 9 that the result is present, and after 10 that the pulse has cleared. All samples are taken on falling edges.

// File: rtl/kd_pkg.sv
package kd_pkg;
  parameter int unsigned KD_CODE_W = 5;
  parameter int unsigned KD_DEPTH  = 8;

  function automatic int unsigned kd_ptr_w(input int unsigned depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction
endpackage

// File: rtl/kd_sample_ring.sv
module kd_sample_ring #(
  parameter int unsigned CODE_W = kd_pkg::KD_CODE_W,
  parameter int unsigned DEPTH  = kd_pkg::KD_DEPTH,
  localparam int unsigned PTR_W = kd_pkg::kd_ptr_w(DEPTH)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [CODE_W-1:0]         code_i,
  output logic [DEPTH*CODE_W-1:0]   slots_o
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            ptr_q <= '0;
    else if (ptr_q == LAST) ptr_q <= '0;
    else                    ptr_q <= ptr_q + 1'b1;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [CODE_W-1:0] slot_q;
    // distinct preset values keep the ring from matching right after reset
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                   slot_q <= CODE_W'(g);
      else if (ptr_q == PTR_W'(g))   slot_q <= code_i;
    end
    assign slots_o[g*CODE_W +: CODE_W] = slot_q;
  end
endmodule

// File: rtl/kd_match.sv
module kd_match #(
  parameter int unsigned CODE_W = kd_pkg::KD_CODE_W,
  parameter int unsigned DEPTH  = kd_pkg::KD_DEPTH
) (
  input  logic [DEPTH*CODE_W-1:0] slots_i,
  output logic                    all_eq_o,
  output logic [CODE_W-1:0]       ref_o
);
  logic [DEPTH-1:0] eq;

  assign ref_o = slots_i[CODE_W-1:0];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign eq[g] = (slots_i[g*CODE_W +: CODE_W] == ref_o);
  end

  assign all_eq_o = &eq;
endmodule

// File: rtl/kd_out_stage.sv
module kd_out_stage #(
  parameter int unsigned CODE_W = kd_pkg::KD_CODE_W,
  localparam logic [CODE_W-1:0] IDLE = {CODE_W{1'b1}}
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              all_eq_i,
  input  logic [CODE_W-1:0] ref_i,
  output logic [CODE_W-1:0] stable_o,
  output logic              start_no,
  output logic              valid_o
);
  logic [CODE_W-1:0] stable_q;
  logic              start_nq;
  logic              valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stable_q <= IDLE;
      start_nq <= 1'b1;
      valid_q  <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (all_eq_i) begin
        stable_q <= ref_i;
        start_nq <= 1'b0;
        valid_q  <= (ref_i != stable_q) && (ref_i != IDLE);
      end
    end
  end

  assign stable_o = stable_q;
  assign start_no = start_nq;
  assign valid_o  = valid_q;
endmodule

// File: rtl/keypad_debounce.sv
module keypad_debounce #(
  parameter int unsigned CODE_W = kd_pkg::KD_CODE_W,
  parameter int unsigned DEPTH  = kd_pkg::KD_DEPTH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] raw_code_i,
  output logic [CODE_W-1:0] stable_code_o,
  output logic              start_no,
  output logic              key_valid_o
);
  logic [DEPTH*CODE_W-1:0] slots;
  logic                    all_eq;
  logic [CODE_W-1:0]       ref_code;

  kd_sample_ring #(.CODE_W(CODE_W), .DEPTH(DEPTH)) u_ring (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .code_i  (raw_code_i),
    .slots_o (slots)
  );

  kd_match #(.CODE_W(CODE_W), .DEPTH(DEPTH)) u_match (
    .slots_i  (slots),
    .all_eq_o (all_eq),
    .ref_o    (ref_code)
  );

  kd_out_stage #(.CODE_W(CODE_W)) u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .all_eq_i (all_eq),
    .ref_i    (ref_code),
    .stable_o (stable_code_o),
    .start_no (start_no),
    .valid_o  (key_valid_o)
  );
endmodule

// File: rtl/kd_checker.sv
module kd_checker #(
  parameter int unsigned CODE_W = kd_pkg::KD_CODE_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [CODE_W-1:0] raw_code_i,
  input logic [CODE_W-1:0] stable_code_o,
  input logic              start_no,
  input logic              key_valid_o
);
  localparam logic [CODE_W-1:0] IDLE = {CODE_W{1'b1}};

  // R4
  start_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_no |=> !start_no);

  // R5
  valid_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_valid_o |=> !key_valid_o);

  // R6
  idle_no_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stable_code_o == IDLE) |-> !key_valid_o);

  // R4
  accept_clears_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_valid_o |-> !start_no);

  // R2
  accept_from_raw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(stable_code_o) |-> (stable_code_o == $past(raw_code_i, 2)));
endmodule

bind keypad_debounce kd_checker #(.CODE_W(CODE_W)) u_kd_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .raw_code_i    (raw_code_i),
  .stable_code_o (stable_code_o),
  .start_no      (start_no),
  .key_valid_o   (key_valid_o)
);

// File: tb/tb_keypad_debounce.sv
module tb_keypad_debounce;
  localparam logic [4:0] IDLE = 5'h1F;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [4:0] raw = IDLE;
  logic [4:0] stable;
  logic       start_n;
  logic       kv;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  keypad_debounce dut (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .raw_code_i    (raw),
    .stable_code_o (stable),
    .start_no      (start_n),
    .key_valid_o   (kv)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    raw = IDLE;
    step(2);
    check(stable == IDLE, "R1 code", stable, IDLE);
    check(start_n == 1'b1, "R1 start", start_n, 1);
    check(kv == 1'b0, "R1 valid", kv, 0);
    rst_ni = 1'b1;
    step(1);
    check(start_n == 1'b1 && stable == IDLE, "R1 first cycle", start_n, 1);
    step(7);
    check(start_n == 1'b1, "R8 no early accept", start_n, 1);
    step(1);
    check(start_n == 1'b0, "R4 start falls", start_n, 0);
    check(stable == IDLE && kv == 1'b0, "R6 idle accepted silently", kv, 0);
  endtask

  task automatic t_press(input logic [4:0] code);
    raw = code;
    step(8);
    check(stable == IDLE, "R2 not before 9th edge", stable, IDLE);
    step(1);
    check(stable == code, "R2 accepted", stable, code);
    check(kv == 1'b1, "R5 pulse", kv, 1);
    step(1);
    check(kv == 1'b0, "R5 pulse width", kv, 0);
  endtask

  task automatic t_hold(input logic [4:0] code);
    int seen = 0;
    for (int i = 0; i < 20; i++) begin
      step(1);
      if (kv) seen++;
    end
    check(seen == 0, "R7 no repeat pulse", seen, 0);
    check(stable == code, "R7 code kept", stable, code);
  endtask

  task automatic t_release();
    int seen = 0;
    raw = IDLE;
    for (int i = 0; i < 9; i++) begin
      step(1);
      if (kv) seen++;
    end
    check(stable == IDLE, "R6 idle accepted", stable, IDLE);
    check(seen == 0, "R6 no pulse", seen, 0);
    check(start_n == 1'b0, "R4 start stays low", start_n, 0);
  endtask

  task automatic t_bounce();
    int moved = 0;
    for (int i = 0; i < 40; i++) begin
      raw = (i % 2) ? 5'h07 : IDLE;
      step(1);
      if (stable != IDLE) moved++;
    end
    check(moved == 0, "R3 chatter rejected", moved, 0);
    raw = 5'h06;
    step(7);
    raw = IDLE;
    step(1);
    raw = 5'h06;
    step(8);
    check(stable == IDLE, "R3 glitch restarts window", stable, IDLE);
    step(1);
    check(stable == 5'h06 && kv, "R2 accepted after glitch", stable, 6);
  endtask

  task automatic t_reset_mid();
    raw = 5'h0A;
    step(3);
    rst_ni = 1'b0;
    step(1);
    check(stable == IDLE && start_n && !kv, "R1 mid reset", stable, IDLE);
    rst_ni = 1'b1;
    step(8);
    check(start_n == 1'b1, "R8 no accept after reset", start_n, 1);
    step(1);
    check(stable == 5'h0A && kv && !start_n, "R5 pulse after reset", stable, 5'h0A);
  endtask

  initial begin
    step(1);
    t_reset();
    t_press(5'h03);
    t_hold(5'h03);
    t_release();
    t_press(5'h0C);
    t_release();
    t_bounce();
    t_reset_mid();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule